// File: doc/BRIEF.md
# Pipeline Hazard and Early-Branch Control

This block is the interlock and steering logic for a five-stage in-order integer pipeline whose stages run fetch, decode/register-read, execute, memory access and write-back, in that order. Each cycle it looks at the instruction sitting in decode/register-read: its class, its source register numbers and its destination. It keeps its own shadow record of which registers the instructions further down the pipe will write. From this it decides whether decode must hold (freezing the PC and the fetch/decode register while a bubble enters execute), which operand source the execute-stage multiplexers should pick, and whether a branch resolved in decode is taken.

Branches are decided in decode by a dedicated equality comparator. It XORs the two 32-bit operand values and OR-reduces the result, so a taken branch discards only the one instruction fetched after it. A static strap selects between full operand bypassing and no bypassing. With no bypassing, a consumer waits until its producer reaches write-back. The register file is taken to write in the first half of a cycle and read in the second half, so a value being written back can be read in the same cycle.

The unit drives control and select signals only. The register file, execute unit, memories and the multiplexers themselves belong to the datapath.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: After reset the pipeline shadow is empty: `stall`, `bubble`, `flush`, `br_taken` are 0 and all select outputs are 0 while decode holds no instruction.
- R2: Class codes on `id_cls` are 0 nop, 1 register-to-register ALU (reads src1 and src2, writes dst), 2 load (reads src1, writes dst), 3 store (reads src1 and src2, writes nothing), 4 branch-if-equal, 5 branch-if-not-equal (both read src1 and src2); codes 6 and 7 act as nop. A store never causes a later reader of its `id_dst` number to stall.
- R3: With `byp_en`=0, a reader of a register written by the instruction one ahead stalls 2 cycles, and two ahead stalls 1 cycle. All forwarding selects stay 0.
- R4: With `byp_en`=1, an ALU result read by the next instruction causes no stall. The execute-stage selects use code 2'b10 (ALU/MEM result) for a producer one ahead and 2'b01 (MEM/WB result) for a producer two ahead, with 2'b10 winning when both match. Code 2'b00 is the register file.
- R5: With `byp_en`=1, a load whose destination is read by the next non-branch instruction costs exactly 1 stall cycle, after which the consumer takes select 2'b01.
- R6: `br_taken` and `flush` are 1 in the decode cycle of an unstalled branch-if-equal whose operands are bitwise equal, or of an unstalled branch-if-not-equal whose operands differ. Otherwise they are 0.
- R7: With `byp_en`=1, a branch reading the result of the ALU instruction directly ahead stalls 1 cycle and then takes that operand through `cmp_fwd_a`/`cmp_fwd_b`=1. A branch reading a load result directly ahead stalls 2 cycles and then reads the register file (select 0).
- R8: Register 0 never causes a stall and never yields a nonzero forwarding select.
- R9: `bubble` equals `stall` in every cycle, a branch is never reported taken while stalled, and an instruction entering execute behind a stall receives no forwarding.
- R10: No instruction stalls more than 2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byp_en | input | 1 | Strap: 1 full bypass, 0 no bypass |
| id_vld | input | 1 | Decode stage holds a valid instruction |
| id_cls | input | 3 | Decode instruction class (codes in R2) |
| id_src1 | input | RW | First source register number |
| id_src2 | input | RW | Second source register number |
| id_dst | input | RW | Destination register number |
| cmp_a | input | DW | First branch operand after the decode select |
| cmp_b | input | DW | Second branch operand after the decode select |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Insert a nop into execute |
| flush | output | 1 | Squash the fetch/decode register |
| br_taken | output | 1 | Decode branch is taken |
| fwd_a | output | 2 | Execute first-operand select |
| fwd_b | output | 2 | Execute second-operand select |
| cmp_fwd_a | output | 1 | Decode first branch operand from ALU/MEM result |
| cmp_fwd_b | output | 1 | Decode second branch operand from ALU/MEM result |

## Verification
Dependent pairs are sent with the producer one and two slots ahead, as ALU, load and store producers feeding ALU and branch consumers. Each pair is run with the strap both off and on, which separates the stall counts of each mode and the forwarding select that picks the value. Overlapping producers of the same register show which forwarding source takes priority, and register 0 in each role shows that it is excluded. Equal operands, unequal operands and operands that differ in only the top bit are applied to both branch kinds to cover the full width of the comparator, and a branch that is stalled with equal operands shows that it is not taken while held.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byp_en,
  input  logic          id_vld,
  input  logic [2:0]    id_cls,
  input  logic [RW-1:0] id_src1,
  input  logic [RW-1:0] id_src2,
  input  logic [RW-1:0] id_dst,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  output logic          stall,
  output logic          bubble,
  output logic          flush,
  output logic          br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          cmp_fwd_a,
  output logic          cmp_fwd_b
);
  localparam logic [2:0] K_ALU = 3'd1;
  localparam logic [2:0] K_LD  = 3'd2;
  localparam logic [2:0] K_ST  = 3'd3;
  localparam logic [2:0] K_BEQ = 3'd4;
  localparam logic [2:0] K_BNE = 3'd5;
  localparam logic [RW-1:0] RZ = '0;

  function automatic logic hit(input logic [RW-1:0] s, input logic [RW-1:0] d);
    return (s != RZ) && (s == d);
  endfunction

  logic [RW-1:0] ex_dst, ex_s1, ex_s2, mem_dst, wb_dst;
  logic          ex_ld, mem_ld;

  wire is_alu = id_vld && id_cls == K_ALU;
  wire is_ld  = id_vld && id_cls == K_LD;
  wire is_st  = id_vld && id_cls == K_ST;
  wire is_beq = id_vld && id_cls == K_BEQ;
  wire is_bne = id_vld && id_cls == K_BNE;
  wire is_br  = is_beq || is_bne;

  wire [RW-1:0] s1 = (is_alu || is_ld || is_st || is_br) ? id_src1 : RZ;
  wire [RW-1:0] s2 = (is_alu || is_st || is_br) ? id_src2 : RZ;
  wire [RW-1:0] dw = (is_alu || is_ld) ? id_dst : RZ;

  wire hz_ex  = hit(s1, ex_dst)  || hit(s2, ex_dst);
  wire hz_mem = hit(s1, mem_dst) || hit(s2, mem_dst);

  wire stall_byp = is_br ? (hz_ex || (mem_ld && hz_mem)) : (ex_ld && hz_ex);
  assign stall  = byp_en ? stall_byp : (hz_ex || hz_mem);
  assign bubble = stall;

  wire same = ~|(cmp_a ^ cmp_b);
  assign br_taken = !stall && ((is_beq && same) || (is_bne && !same));
  assign flush    = br_taken;

  assign cmp_fwd_a = byp_en && is_br && !mem_ld && hit(s1, mem_dst);
  assign cmp_fwd_b = byp_en && is_br && !mem_ld && hit(s2, mem_dst);

  function automatic logic [1:0] pick(input logic [RW-1:0] s, input logic en,
                                      input logic [RW-1:0] m, input logic [RW-1:0] w);
    if (!en)         return 2'b00;
    else if (hit(s, m)) return 2'b10;
    else if (hit(s, w)) return 2'b01;
    else             return 2'b00;
  endfunction

  assign fwd_a = pick(ex_s1, byp_en, mem_dst, wb_dst);
  assign fwd_b = pick(ex_s2, byp_en, mem_dst, wb_dst);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_dst <= RZ; ex_s1 <= RZ; ex_s2 <= RZ; ex_ld <= 1'b0;
      mem_dst <= RZ; mem_ld <= 1'b0; wb_dst <= RZ;
    end else begin
      ex_dst  <= stall ? RZ : dw;
      ex_s1   <= stall ? RZ : s1;
      ex_s2   <= stall ? RZ : s2;
      ex_ld   <= !stall && is_ld;
      mem_dst <= ex_dst;
      mem_ld  <= ex_ld;
      wb_dst  <= mem_dst;
    end
  end

  logic [1:0] stall_run;
  always_ff @(posedge clk) begin
    if (!rst_n)     stall_run <= 2'd0;
    else if (!stall) stall_run <= 2'd0;
    else if (stall_run != 2'd3) stall_run <= stall_run + 2'd1;
  end

  // R10
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run == 2'd2 |-> !stall);

  // R9
  fwd_after_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00 || fwd_b != 2'b00) |-> !$past(stall));

  // R3
  nobyp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_en |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !cmp_fwd_a && !cmp_fwd_b));

  // R8
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fwd_a |-> id_src1 != RZ) and (cmp_fwd_b |-> id_src2 != RZ));

  // R6
  taken_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (id_vld && (id_cls == K_BEQ || id_cls == K_BNE)));
endmodule

// File: tb/pipe_hazard_ctl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_tb;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam logic [2:0] NOP = 3'd0, ALU = 3'd1, LD = 3'd2, ST = 3'd3, BEQ = 3'd4, BNE = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, byp_en = 1'b0, id_vld = 1'b0;
  logic [2:0] id_cls = NOP;
  logic [RW-1:0] id_src1 = '0, id_src2 = '0, id_dst = '0;
  logic [DW-1:0] cmp_a = '0, cmp_b = '0;
  logic stall, bubble, flush, br_taken, cmp_fwd_a, cmp_fwd_b;
  logic [1:0] fwd_a, fwd_b;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctl #(.RW(RW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .byp_en(byp_en), .id_vld(id_vld), .id_cls(id_cls),
    .id_src1(id_src1), .id_src2(id_src2), .id_dst(id_dst), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .stall(stall), .bubble(bubble), .flush(flush), .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .cmp_fwd_a(cmp_fwd_a), .cmp_fwd_b(cmp_fwd_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c, input int a, input int b, input int d,
                      input int exp_st, input string req);
    int n = 0;
    id_vld = (c != NOP); id_cls = c;
    id_src1 = RW'(a); id_src2 = RW'(b); id_dst = RW'(d);
    #1;
    while (stall && n < 6) begin
      chk(bubble == 1'b1, "R9 bubble", int'(bubble), 1);
      @(posedge clk); @(negedge clk); #1;
      n++;
    end
    chk(n == exp_st, req, n, exp_st);
  endtask

  task automatic adv();
    @(posedge clk); @(negedge clk);
    id_vld = 1'b0; id_cls = NOP; id_src1 = '0; id_src2 = '0; id_dst = '0;
    #1;
  endtask

  task automatic drain();
    repeat (3) adv();
  endtask

  task automatic t_reset();
    chk(!stall && !bubble && !flush && !br_taken, "R1 ctl idle", int'(stall), 0);
    chk(fwd_a == 2'b00 && fwd_b == 2'b00, "R1 fwd idle", int'(fwd_a), 0);
    chk(!cmp_fwd_a && !cmp_fwd_b, "R1 cmp sel idle", int'(cmp_fwd_a), 0);
  endtask

  task automatic t_nobyp();
    byp_en = 1'b0; drain();
    send(ALU, 1, 2, 3, 0, "R3 producer");      adv();
    send(ALU, 3, 6, 4, 2, "R3 adjacent alu");  adv();
    chk(fwd_a == 2'b00, "R3 no fwd", int'(fwd_a), 0);
    send(ALU, 1, 2, 5, 0, "R3 producer2");     adv();
    send(NOP, 0, 0, 0, 0, "R3 gap");           adv();
    send(ALU, 2, 5, 6, 1, "R3 gap one");       adv();
    send(LD, 1, 0, 7, 0, "R3 load");           adv();
    send(ALU, 7, 7, 8, 2, "R3 load use");      adv();
    drain();
    send(ST, 1, 2, 12, 0, "R2 store");         adv();
    send(ALU, 12, 12, 13, 0, "R2 store no write"); adv();
  endtask

  task automatic t_byp_alu();
    byp_en = 1'b1; drain();
    send(ALU, 1, 2, 3, 0, "R4 producer");      adv();
    send(ALU, 3, 6, 4, 0, "R4 no stall");      adv();
    chk(fwd_a == 2'b10 && fwd_b == 2'b00, "R4 one ahead", int'(fwd_a), 2);
    send(ALU, 1, 1, 8, 0, "R4 p1");            adv();
    send(ALU, 2, 2, 8, 0, "R4 p2");            adv();
    send(ALU, 8, 8, 9, 0, "R4 double");        adv();
    chk(fwd_a == 2'b10 && fwd_b == 2'b10, "R4 priority", int'(fwd_b), 2);
    drain();
    send(ALU, 1, 2, 10, 0, "R4 p3");           adv();
    send(NOP, 0, 0, 0, 0, "R4 gap");           adv();
    send(ALU, 5, 10, 11, 0, "R4 two ahead");   adv();
    chk(fwd_b == 2'b01 && fwd_a == 2'b00, "R4 two ahead sel", int'(fwd_b), 1);
  endtask

  task automatic t_load_use();
    byp_en = 1'b1; drain();
    send(LD, 1, 0, 7, 0, "R5 load");           adv();
    send(ALU, 7, 2, 4, 1, "R5 load use");      adv();
    chk(fwd_a == 2'b01, "R5 wb sel", int'(fwd_a), 1);
    drain();
    send(ALU, 1, 2, 12, 0, "R2 alu to store"); adv();
    send(ST, 13, 12, 0, 0, "R2 store read");   adv();
    chk(fwd_b == 2'b10, "R2 store data fwd", int'(fwd_b), 2);
  endtask

  task automatic t_cmp();
    byp_en = 1'b1; drain();
    cmp_a = 32'd5; cmp_b = 32'd5;
    send(BEQ, 1, 2, 0, 0, "R6 beq");
    chk(br_taken && flush, "R6 beq equal", int'(br_taken), 1);
    cmp_b = 32'd6; #1;
    chk(!br_taken && !flush, "R6 beq differ", int'(br_taken), 0);
    id_cls = BNE; #1;
    chk(br_taken && flush, "R6 bne differ", int'(br_taken), 1);
    cmp_a = 32'h8000_0000; cmp_b = 32'h0; id_cls = BEQ; #1;
    chk(!br_taken, "R6 beq top bit", int'(br_taken), 0);
    cmp_b = 32'h8000_0000; id_cls = BNE; #1;
    chk(!br_taken, "R6 bne equal", int'(br_taken), 0);
    adv();
  endtask

  task automatic t_br_hazard();
    byp_en = 1'b1; drain();
    cmp_a = 32'd9; cmp_b = 32'd9;
    send(ALU, 1, 2, 3, 0, "R7 producer");      adv();
    id_vld = 1'b1; id_cls = BEQ; id_src1 = 5'd3; id_src2 = 5'd4; #1;
    chk(stall && !br_taken && !flush, "R9 held branch", int'(br_taken), 0);
    send(BEQ, 3, 4, 0, 1, "R7 alu to branch");
    chk(cmp_fwd_a && !cmp_fwd_b, "R7 cmp fwd", int'(cmp_fwd_a), 1);
    chk(br_taken && flush, "R7 taken after stall", int'(br_taken), 1);
    adv(); drain();
    send(LD, 1, 0, 7, 0, "R7 load");           adv();
    send(BNE, 2, 7, 0, 2, "R7 load to branch");
    chk(!cmp_fwd_a && !cmp_fwd_b, "R7 regfile read", int'(cmp_fwd_b), 0);
    adv();
    byp_en = 1'b0; drain();
    send(ALU, 1, 2, 3, 0, "R3 br producer");   adv();
    send(BEQ, 3, 4, 0, 2, "R3 branch nobyp");
    chk(!cmp_fwd_a, "R3 branch no sel", int'(cmp_fwd_a), 0);
    adv();
  endtask

  task automatic t_zero();
    byp_en = 1'b1; drain();
    send(ALU, 1, 2, 0, 0, "R8 write r0");      adv();
    send(ALU, 0, 0, 5, 0, "R8 read r0");       adv();
    chk(fwd_a == 2'b00 && fwd_b == 2'b00, "R8 no fwd", int'(fwd_a), 0);
    send(LD, 1, 0, 0, 0, "R8 load r0");        adv();
    send(BEQ, 0, 0, 0, 0, "R8 branch r0");
    chk(!cmp_fwd_a && !cmp_fwd_b, "R8 no cmp sel", int'(cmp_fwd_a), 0);
    adv();
    byp_en = 1'b0; drain();
    send(ALU, 1, 2, 0, 0, "R8 nobyp w");       adv();
    send(ALU, 0, 0, 6, 0, "R8 nobyp r");       adv();
  endtask

  initial begin
    #200000;
    chk(1'b0, "R10 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_nobyp();
    t_byp_alu();
    t_load_use();
    t_cmp();
    t_br_hazard();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule